// File: doc/BRIEF.md
# Reorder Buffer with Precise Commit

This block keeps instructions in program order while their results arrive in any order. At decode an instruction claims the slot at the tail of a circular buffer, and the slot number becomes its tag. When a functional unit finishes, it writes the result, plus a store address and a fault flag, into the slot named by the tag. Retirement only looks at the head slot. A completed, fault-free head is committed to the register write port or to the store port. A completed head with a fault is not committed. Instead the whole buffer is discarded and a redirect carrying the faulting instruction's PC is raised.

A small rename map records, for each architectural register, the tag of its newest pending producer. A consumer asks about a source register through the lookup port. The port tells it whether the register is pending, which tag will produce it, and, if that slot has already completed, the forwarded value. Because every in-flight result lives in its own slot, reuse of a register name by a later instruction causes no write-after-write or write-after-read hazard.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `cm_reg_we`, `cm_st_we` and `flush_valid` are 0.
- R2: Each accepted allocation is given the tag shown on `alloc_tag` in the cycle it is presented. Tags run 0, 1, 2, … and wrap modulo `ROB_DEPTH`.
- R3: With `ROB_DEPTH` entries in flight, `alloc_ready` is 0. An allocation offered in that state is dropped and `alloc_tag` does not advance. This holds even if a commit happens in the same cycle.
- R4: Completed entries retire strictly oldest first, one per cycle. A commit's outputs are valid for one cycle, on the second clock edge after the completion that made the head ready.
- R5: A completed entry that is not the oldest stays in the buffer and produces no commit until every older entry has retired.
- R6: An entry allocated as a store retires through `cm_st_we`, `cm_st_addr` (the completion's `cmp_addr`) and `cm_st_data` (the completion's `cmp_value`), and never through `cm_reg_we`. At most one of `cm_reg_we`, `cm_st_we` and `flush_valid` is high in any cycle.
- R7: The lookup outputs reflect `lk_reg` as sampled at the previous edge. `lk_pending` reports that a producer is still in flight, and `lk_tag` gives its tag. If that producer has completed, `lk_ready` is 1 and `lk_value` holds its result.
- R8: The rename map always follows the newest writer of a register. Retiring an older writer of the same register leaves the register pending on the newer one.
- R9: A completed head with its fault flag set is not committed. One cycle later `flush_valid` pulses with `flush_pc` equal to that entry's PC. The buffer is then empty, and `alloc_tag` equals the faulting entry's tag. Later completions aimed at discarded tags produce no commit.
- R10: A fault flag on an entry that is not the oldest has no effect until that entry reaches the head. All older entries commit normally first.
- R11: After a flush every register reads back as not pending on the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_has_dest | input | 1 | Instruction writes a register |
| alloc_is_store | input | 1 | Instruction is a store |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_ready | output | 1 | A free slot exists |
| alloc_tag | output | IDX_W | Tag given to the offered instruction |
| cmp_valid | input | 1 | Completion write strobe |
| cmp_tag | input | IDX_W | Slot being completed |
| cmp_value | input | XLEN | Result, or store data |
| cmp_addr | input | XLEN | Store address |
| cmp_exc | input | 1 | Instruction faulted |
| lk_reg | input | AREG_W | Source register to look up |
| lk_pending | output | 1 | Register has an in-flight producer |
| lk_tag | output | IDX_W | Tag of that producer |
| lk_ready | output | 1 | Producer has completed |
| lk_value | output | XLEN | Forwarded value |
| cm_reg_we | output | 1 | Register commit strobe |
| cm_reg_idx | output | AREG_W | Register being written |
| cm_reg_data | output | XLEN | Value being written |
| cm_st_we | output | 1 | Store commit strobe |
| cm_st_addr | output | XLEN | Store address |
| cm_st_data | output | XLEN | Store data |
| cm_tag | output | IDX_W | Tag of the retiring entry |
| flush_valid | output | 1 | Fault redirect strobe |
| flush_pc | output | PC_W | PC of the faulting instruction |

## Verification
`alloc_tag` and `alloc_ready` come straight from registers, so the bench reads them before the allocating edge. Lookup results are due one edge after `lk_reg` is driven. A commit or flush is due on the second edge after the completion that readies the head, and each further in-order commit follows one edge later. The bench drives inputs on falling edges and logs commit and flush strobes with a falling-edge monitor. It then waits a fixed number of cycles, longer than the latest commit can take, before comparing the log counts and contents. This makes each check independent of exactly when within that window a strobe landed, while a missing or extra commit still shows up in the counts.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_REG   = 2'd1,
    RK_STORE = 2'd2,
    RK_FLUSH = 2'd3
  } retire_kind_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);

  logic [IDX_W:0] head_q, tail_q;
  logic [IDX_W:0] occupancy;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx  = head_q[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];
  assign empty     = (head_q == tail_q);
  assign full      = (head_q[IDX_W] != tail_q[IDX_W]) &&
                     (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);
  assign occupancy = tail_q - head_q;

  p_occupancy_r3: assert property (@(posedge clk) disable iff (rst)
    occupancy <= (IDX_W+1)'(DEPTH));

  p_pop_needs_entry_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NUM_AREGS = 16,
  parameter int DEPTH     = 8,
  localparam int AREG_W = $clog2(NUM_AREGS),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              set_en,
  input  logic [AREG_W-1:0] set_reg,
  input  logic [IDX_W-1:0]  set_tag,
  input  logic              clr_en,
  input  logic [AREG_W-1:0] clr_reg,
  input  logic [IDX_W-1:0]  clr_tag,
  input  logic [AREG_W-1:0] rd_reg,
  output logic              rd_pending,
  output logic [IDX_W-1:0]  rd_tag
);

  logic [NUM_AREGS-1:0] map_v;
  logic [IDX_W-1:0]     map_t [NUM_AREGS];

  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        map_v[g] <= 1'b0;
        map_t[g] <= '0;
      end else if (set_en && set_reg == AREG_W'(g)) begin
        map_v[g] <= 1'b1;
        map_t[g] <= set_tag;
      end else if (clr_en && clr_reg == AREG_W'(g) && map_t[g] == clr_tag) begin
        map_v[g] <= 1'b0;
      end
    end
  end

  assign rd_pending = map_v[rd_reg];
  assign rd_tag     = map_t[rd_reg];

  p_keep_newer_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && map_v[clr_reg] && map_t[clr_reg] != clr_tag && !flush)
      |=> map_v[$past(clr_reg)]);

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (map_v == '0));

endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH     = 8,
  parameter int NUM_AREGS = 16,
  parameter int XLEN      = 32,
  parameter int PC_W      = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int AREG_W = $clog2(NUM_AREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              al_en,
  input  logic [IDX_W-1:0]  al_idx,
  input  logic [AREG_W-1:0] al_dest,
  input  logic              al_has_dest,
  input  logic              al_store,
  input  logic [PC_W-1:0]   al_pc,
  input  logic              cp_en,
  input  logic [IDX_W-1:0]  cp_idx,
  input  logic [XLEN-1:0]   cp_value,
  input  logic [XLEN-1:0]   cp_addr,
  input  logic              cp_exc,
  input  logic              fr_en,
  input  logic [IDX_W-1:0]  hd_idx,
  output logic              hd_valid,
  output logic              hd_done,
  output logic              hd_exc,
  output logic              hd_has_dest,
  output logic              hd_store,
  output logic [AREG_W-1:0] hd_dest,
  output logic [PC_W-1:0]   hd_pc,
  output logic [XLEN-1:0]   hd_value,
  output logic [XLEN-1:0]   hd_addr,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_done,
  output logic [XLEN-1:0]   lk_value
);

  logic [DEPTH-1:0]  valid_q, done_q, exc_q, hasd_q, store_q;
  logic [AREG_W-1:0] dest_m  [DEPTH];
  logic [PC_W-1:0]   pc_m    [DEPTH];
  logic [XLEN-1:0]   value_m [DEPTH];
  logic [XLEN-1:0]   addr_m  [DEPTH];
  logic              cp_hit;

  assign cp_hit = cp_en && valid_q[cp_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
      hasd_q  <= '0;
      store_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      if (fr_en) valid_q[hd_idx] <= 1'b0;
      if (al_en) begin
        valid_q[al_idx] <= 1'b1;
        done_q[al_idx]  <= 1'b0;
        exc_q[al_idx]   <= 1'b0;
        hasd_q[al_idx]  <= al_has_dest;
        store_q[al_idx] <= al_store;
      end
      if (cp_hit) begin
        done_q[cp_idx] <= 1'b1;
        exc_q[cp_idx]  <= cp_exc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (al_en) begin
      dest_m[al_idx] <= al_dest;
      pc_m[al_idx]   <= al_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (cp_hit && !flush) begin
      value_m[cp_idx] <= cp_value;
      addr_m[cp_idx]  <= cp_addr;
    end
  end

  assign hd_valid    = valid_q[hd_idx];
  assign hd_done     = done_q[hd_idx];
  assign hd_exc      = exc_q[hd_idx];
  assign hd_has_dest = hasd_q[hd_idx];
  assign hd_store    = store_q[hd_idx];
  assign hd_dest     = dest_m[hd_idx];
  assign hd_pc       = pc_m[hd_idx];
  assign hd_value    = value_m[hd_idx];
  assign hd_addr     = addr_m[hd_idx];
  assign lk_done     = valid_q[lk_idx] && done_q[lk_idx];
  assign lk_value    = value_m[lk_idx];

  p_alloc_free_slot_r3: assert property (@(posedge clk) disable iff (rst)
    al_en |-> !valid_q[al_idx]);

  p_free_only_done_r5: assert property (@(posedge clk) disable iff (rst)
    fr_en |-> (valid_q[hd_idx] && done_q[hd_idx] && !exc_q[hd_idx]));

endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int ROB_DEPTH = 8,
  parameter int NUM_AREGS = 16,
  parameter int XLEN      = 32,
  parameter int PC_W      = 32,
  localparam int IDX_W  = $clog2(ROB_DEPTH),
  localparam int AREG_W = $clog2(NUM_AREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic              alloc_has_dest,
  input  logic              alloc_is_store,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [XLEN-1:0]   cmp_value,
  input  logic [XLEN-1:0]   cmp_addr,
  input  logic              cmp_exc,
  input  logic [AREG_W-1:0] lk_reg,
  output logic              lk_pending,
  output logic [IDX_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [XLEN-1:0]   lk_value,
  output logic              cm_reg_we,
  output logic [AREG_W-1:0] cm_reg_idx,
  output logic [XLEN-1:0]   cm_reg_data,
  output logic              cm_st_we,
  output logic [XLEN-1:0]   cm_st_addr,
  output logic [XLEN-1:0]   cm_st_data,
  output logic [IDX_W-1:0]  cm_tag,
  output logic              flush_valid,
  output logic [PC_W-1:0]   flush_pc
);
  import rob_pkg::*;

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, empty;
  logic              h_valid, h_done, h_exc, h_has_dest, h_store;
  logic [AREG_W-1:0] h_dest;
  logic [PC_W-1:0]   h_pc;
  logic [XLEN-1:0]   h_value, h_addr;
  logic              map_pending;
  logic [IDX_W-1:0]  map_tag;
  logic              src_done;
  logic [XLEN-1:0]   src_value;
  logic              push, retire, squash;
  retire_kind_e      kind;

  always_comb begin
    kind = RK_NONE;
    if (h_valid && h_done) begin
      if (h_exc)                    kind = RK_FLUSH;
      else if (h_store)             kind = RK_STORE;
      else if (h_has_dest)          kind = RK_REG;
      else                          kind = RK_NONE;
    end
  end

  assign squash = (kind == RK_FLUSH);
  assign retire = h_valid && h_done && !h_exc;
  assign push   = alloc_valid && !full && !squash;

  rob_ptrs #(.DEPTH(ROB_DEPTH)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (retire),
    .flush    (squash),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .full     (full),
    .empty    (empty)
  );

  rob_rename #(.NUM_AREGS(NUM_AREGS), .DEPTH(ROB_DEPTH)) u_rename (
    .clk        (clk),
    .rst        (rst),
    .flush      (squash),
    .set_en     (push && alloc_has_dest && !alloc_is_store),
    .set_reg    (alloc_dest),
    .set_tag    (tail_idx),
    .clr_en     (retire && h_has_dest && !h_store),
    .clr_reg    (h_dest),
    .clr_tag    (head_idx),
    .rd_reg     (lk_reg),
    .rd_pending (map_pending),
    .rd_tag     (map_tag)
  );

  rob_entries #(
    .DEPTH(ROB_DEPTH), .NUM_AREGS(NUM_AREGS), .XLEN(XLEN), .PC_W(PC_W)
  ) u_entries (
    .clk         (clk),
    .rst         (rst),
    .flush       (squash),
    .al_en       (push),
    .al_idx      (tail_idx),
    .al_dest     (alloc_dest),
    .al_has_dest (alloc_has_dest && !alloc_is_store),
    .al_store    (alloc_is_store),
    .al_pc       (alloc_pc),
    .cp_en       (cmp_valid),
    .cp_idx      (cmp_tag),
    .cp_value    (cmp_value),
    .cp_addr     (cmp_addr),
    .cp_exc      (cmp_exc),
    .fr_en       (retire),
    .hd_idx      (head_idx),
    .hd_valid    (h_valid),
    .hd_done     (h_done),
    .hd_exc      (h_exc),
    .hd_has_dest (h_has_dest),
    .hd_store    (h_store),
    .hd_dest     (h_dest),
    .hd_pc       (h_pc),
    .hd_value    (h_value),
    .hd_addr     (h_addr),
    .lk_idx      (map_tag),
    .lk_done     (src_done),
    .lk_value    (src_value)
  );

  assign alloc_ready = !full;
  assign alloc_tag   = tail_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_reg_we   <= 1'b0;
      cm_st_we    <= 1'b0;
      flush_valid <= 1'b0;
      cm_reg_idx  <= '0;
      cm_reg_data <= '0;
      cm_st_addr  <= '0;
      cm_st_data  <= '0;
      cm_tag      <= '0;
      flush_pc    <= '0;
      lk_pending  <= 1'b0;
      lk_tag      <= '0;
      lk_ready    <= 1'b0;
      lk_value    <= '0;
    end else begin
      cm_reg_we   <= (kind == RK_REG);
      cm_st_we    <= (kind == RK_STORE);
      flush_valid <= (kind == RK_FLUSH);
      if (retire || squash) cm_tag <= head_idx;
      if (kind == RK_REG) begin
        cm_reg_idx  <= h_dest;
        cm_reg_data <= h_value;
      end
      if (kind == RK_STORE) begin
        cm_st_addr <= h_addr;
        cm_st_data <= h_value;
      end
      if (squash) flush_pc <= h_pc;
      lk_pending <= map_pending;
      lk_tag     <= map_tag;
      lk_ready   <= map_pending && src_done;
      lk_value   <= src_value;
    end
  end

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cm_reg_we, cm_st_we, flush_valid}));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (empty && alloc_ready));

  p_head_advance_r4: assert property (@(posedge clk) disable iff (rst)
    retire |=> (head_idx == IDX_W'($past(head_idx) + 1'b1)));

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(alloc_tag));

  p_exc_waits_head_r10: assert property (@(posedge clk) disable iff (rst)
    (!h_valid || !h_done || !h_exc) |=> !flush_valid);

endmodule

// File: tb/rob_core_test.sv
module rob_core_test;

  localparam int DEPTH = 8;
  localparam int NREGS = 16;
  localparam int XLEN  = 32;
  localparam int PC_W  = 32;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              alloc_valid = 0, alloc_has_dest = 0, alloc_is_store = 0;
  logic [AW-1:0]     alloc_dest = '0;
  logic [PC_W-1:0]   alloc_pc = '0;
  logic              alloc_ready;
  logic [IDX_W-1:0]  alloc_tag;
  logic              cmp_valid = 0, cmp_exc = 0;
  logic [IDX_W-1:0]  cmp_tag = '0;
  logic [XLEN-1:0]   cmp_value = '0, cmp_addr = '0;
  logic [AW-1:0]     lk_reg = '0;
  logic              lk_pending, lk_ready;
  logic [IDX_W-1:0]  lk_tag, cm_tag;
  logic [XLEN-1:0]   lk_value, cm_reg_data, cm_st_addr, cm_st_data;
  logic              cm_reg_we, cm_st_we, flush_valid;
  logic [AW-1:0]     cm_reg_idx;
  logic [PC_W-1:0]   flush_pc;

  rob_core #(.ROB_DEPTH(DEPTH), .NUM_AREGS(NREGS), .XLEN(XLEN), .PC_W(PC_W)) uut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_has_dest(alloc_has_dest),
    .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_addr(cmp_addr), .cmp_exc(cmp_exc),
    .lk_reg(lk_reg), .lk_pending(lk_pending), .lk_tag(lk_tag),
    .lk_ready(lk_ready), .lk_value(lk_value),
    .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx), .cm_reg_data(cm_reg_data),
    .cm_st_we(cm_st_we), .cm_st_addr(cm_st_addr), .cm_st_data(cm_st_data),
    .cm_tag(cm_tag), .flush_valid(flush_valid), .flush_pc(flush_pc)
  );

  int total = 0;
  int bad   = 0;

  // commit / flush log, sampled on falling edges
  int            n_reg = 0, n_st = 0, n_fl = 0;
  logic [AW-1:0]   log_idx  [32];
  logic [XLEN-1:0] log_data [32];
  logic [XLEN-1:0] last_st_addr, last_st_data;
  logic [PC_W-1:0] last_fl_pc;

  always @(negedge clk) begin
    if (!rst) begin
      if (cm_reg_we && n_reg < 32) begin
        log_idx[n_reg]  = cm_reg_idx;
        log_data[n_reg] = cm_reg_data;
        n_reg = n_reg + 1;
      end
      if (cm_st_we) begin
        last_st_addr = cm_st_addr;
        last_st_data = cm_st_data;
        n_st = n_st + 1;
      end
      if (flush_valid) begin
        last_fl_pc = flush_pc;
        n_fl = n_fl + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_alloc(input logic [AW-1:0] d, input bit hd, input bit st,
                          input logic [PC_W-1:0] pc, output logic [IDX_W-1:0] tag,
                          output bit rdy);
    alloc_valid = 1; alloc_dest = d; alloc_has_dest = hd;
    alloc_is_store = st; alloc_pc = pc;
    tag = alloc_tag; rdy = alloc_ready;
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0; alloc_has_dest = 0; alloc_is_store = 0;
  endtask

  task automatic do_cmp(input logic [IDX_W-1:0] t, input logic [XLEN-1:0] v,
                        input logic [XLEN-1:0] a, input bit e);
    cmp_valid = 1; cmp_tag = t; cmp_value = v; cmp_addr = a; cmp_exc = e;
    @(posedge clk);
    @(negedge clk);
    cmp_valid = 0; cmp_exc = 0;
  endtask

  task automatic do_look(input logic [AW-1:0] r);
    lk_reg = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0]  tag;
    logic [31:0] val;
    logic [3:0]  cnt;
  } row_t;

  // completion order vs. commits expected afterwards (R4, R5, R7)
  localparam row_t ROWS [4] = '{
    '{tag: 3'd2, val: 32'h22, cnt: 4'd0},
    '{tag: 3'd1, val: 32'h11, cnt: 4'd0},
    '{tag: 3'd0, val: 32'hAA, cnt: 4'd3},
    '{tag: 3'd3, val: 32'h33, cnt: 4'd4}
  };

  localparam logic [XLEN-1:0] ORDER_DATA [4] = '{32'hAA, 32'h11, 32'h22, 32'h33};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [IDX_W-1:0] t;
    bit r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk(alloc_ready == 1'b1, "R1 ready", alloc_ready, 1);
    chk(alloc_tag == 0, "R1 tag", alloc_tag, 0);
    chk(!cm_reg_we && !cm_st_we && !flush_valid, "R1 outputs",
        {cm_reg_we, cm_st_we, flush_valid}, 0);

    // R2 four register writers, dest r1..r4
    for (int i = 0; i < 4; i++) begin
      do_alloc(AW'(i + 1), 1, 0, PC_W'(32'h100 + 4 * i), t, r);
      chk(t == IDX_W'(i) && r, "R2 sequential tag", t, i);
    end

    // table walk: out-of-order completion, in-order commit
    for (int k = 0; k < 4; k++) begin
      do_cmp(ROWS[k].tag, ROWS[k].val, '0, 0);
      idle(5);
      chk(n_reg == int'(ROWS[k].cnt), "R4/R5 commit count", n_reg, ROWS[k].cnt);
      do_look(AW'(ROWS[k].tag + 1));
      if (int'(ROWS[k].tag) >= int'(ROWS[k].cnt)) begin
        chk(lk_pending && lk_tag == ROWS[k].tag, "R7 pending tag", lk_tag, ROWS[k].tag);
        chk(lk_ready && lk_value == ROWS[k].val, "R7 forwarded value", lk_value, ROWS[k].val);
      end else begin
        chk(!lk_pending, "R7 retired not pending", lk_pending, 0);
      end
    end
    for (int i = 0; i < 4; i++) begin
      chk(log_idx[i] == AW'(i + 1) && log_data[i] == ORDER_DATA[i], "R4 program order",
          log_data[i], ORDER_DATA[i]);
    end

    // R2 wraparound and R3 full: tags 4..7 then 0..3
    do_alloc(5, 1, 0, 32'h140, t, r);
    chk(t == 4, "R2 tag continues", t, 4);
    do_alloc(5, 1, 0, 32'h144, t, r);
    do_alloc(0, 0, 1, 32'h148, t, r);
    do_alloc(7, 1, 0, 32'h200, t, r);
    chk(t == 7, "R2 tag 7", t, 7);
    for (int i = 0; i < 4; i++) begin
      do_alloc(6, 1, 0, PC_W'(32'h300 + 4 * i), t, r);
      chk(t == IDX_W'(i) && r, "R2 tag wraps", t, i);
    end
    chk(!alloc_ready, "R3 full", alloc_ready, 0);
    do_alloc(9, 1, 0, 32'h999, t, r);
    chk(!r && alloc_tag == 4 && !alloc_ready, "R3 dropped alloc", alloc_tag, 4);

    // R10 younger fault and store wait behind incomplete head
    do_cmp(6, 32'hD00D, 32'h80, 0);
    do_cmp(7, 32'h0, 32'h0, 1);
    idle(4);
    chk(n_reg == 4 && n_st == 0 && n_fl == 0, "R10 fault waits", n_fl, 0);
    chk(n_reg == 4, "R5 no early commit", n_reg, 4);

    // R8 older writer of r5 retires; r5 still pending on tag 5
    do_cmp(4, 32'h44, 32'h0, 0);
    idle(4);
    chk(n_reg == 5 && log_data[4] == 32'h44, "R4 head commit", log_data[4], 32'h44);
    do_look(5);
    chk(lk_pending && lk_tag == 5 && !lk_ready, "R8 newest writer kept", lk_tag, 5);

    // tag 5 completes: commit 5, store 6, flush at 7
    do_cmp(5, 32'h55, 32'h0, 0);
    idle(6);
    chk(n_reg == 6 && log_idx[5] == 5 && log_data[5] == 32'h55, "R4 second r5 commit",
        log_data[5], 32'h55);
    chk(n_st == 1 && last_st_addr == 32'h80 && last_st_data == 32'hD00D, "R6 store commit",
        last_st_data, 32'hD00D);
    chk(n_fl == 1 && last_fl_pc == 32'h200, "R9 redirect pc", last_fl_pc, 32'h200);
    chk(alloc_ready && alloc_tag == 7, "R9 empty at fault slot", alloc_tag, 7);

    // R11 rename map cleared
    do_look(6);
    chk(!lk_pending, "R11 r6 not pending", lk_pending, 0);
    do_look(7);
    chk(!lk_pending, "R11 r7 not pending", lk_pending, 0);

    // R9 completion to discarded tag is ignored
    do_cmp(0, 32'hBAD, 32'h0, 0);
    idle(4);
    chk(n_reg == 6 && n_fl == 1, "R9 discarded tag ignored", n_reg, 6);

    // recovery: new instruction reuses faulting slot
    do_alloc(9, 1, 0, 32'h400, t, r);
    chk(t == 7 && r, "R9 alloc after flush", t, 7);
    do_cmp(7, 32'h99, 32'h0, 0);
    idle(4);
    chk(n_reg == 7 && log_idx[6] == 9 && log_data[6] == 32'h99, "R4 commit after flush",
        log_data[6], 32'h99);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule